// File: doc/BRIEF.md
# Shadowed Timekeeping Register Bank

This block sits between a serial access engine and a set of live time-of-day counters. The serial side never touches the counters directly. It reads and writes a user-side copy of seven time registers, plus a protection control byte, a charger configuration byte and a 31-byte scratchpad. The copy is loaded from the live counters at the start of each chip-enable session. The pending time changes are handed back to the counters in one commit pulse when the session ends. A reader therefore sees a time that stays consistent while the counters keep running, and a writer updates the counters in one step.

A three-state machine controls the session. In `ST_IDLE` the bank waits with chip-enable (`sel`) low. It takes the snapshot and moves to `ST_OPEN` in the first cycle that `sel` is seen high. `ST_OPEN` accepts accesses and moves to `ST_COMMIT` in the first cycle that `sel` is seen low. `ST_COMMIT` lasts one cycle, presents the commit to the counters and always returns to `ST_IDLE`.

Accesses carry an address space flag (clock or scratchpad), an index and a burst flag. A clock burst is committed only if all eight burst slots were written. A scratchpad burst stores every byte as it arrives. The charger enable output is decoded from the charger byte.

Top module: `rtc_shadow_bank`

## Requirements
- R1: On the cycle `sel` is first seen high in ST_IDLE, time indices 0-6 are loaded from `live_time` (byte i at bits 8i+7:8i). Reads of those indices during the session return this frozen copy even when `live_time` changes.
- R2: A single (non-burst) write to time index i sets bit i of a pending mask. One cycle after `sel` is seen low, `commit_stb` pulses for one cycle with `commit_mask` equal to that mask and `commit_time` holding the user copy. With no pending write, no pulse occurs.
- R3: A clock burst fills slots 0-7, where slot 7 is the control byte. Only when all eight slots were written does the commit carry mask 0x7F and apply the burst's bit 7 to the protection flag. Otherwise the burst commits nothing.
- R4: Scratchpad writes, in single or burst form, are stored at once, so every byte of a cut-short burst is kept.
- R5: While the protection flag (bit 7 of clock index 7) is 1, writes to time indices, the charger byte (index 8) and the scratchpad are dropped. A single write to index 7 is always accepted.
- R6: A clock burst issued while protection is set changes nothing, not even the control byte.
- R7: Reading clock index 7 returns the protection flag in bit 7 and zeros in bits 6-0, whatever was written.
- R8: `charge_en` is 1 only when charger bits 7-4 are 1010, bits 3-2 are 01 or 10, and bits 1-0 are not 00.
- R9: A burst write to index 8 is ignored. Clock indices 9-31 and scratchpad index 31 read 0x00 and ignore writes.
- R10: During and after reset, the charger byte is 0x00, the protection flag is 1, the scratchpad is zero and `charge_en` is 0.
- R11: Accesses are honoured only in ST_OPEN. In other states writes are ignored and `acc_rdata` reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip-enable level from the serial engine |
| acc_valid | input | 1 | Access strobe, one byte per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ram | input | 1 | 1 = scratchpad space, 0 = clock space |
| acc_burst | input | 1 | Access belongs to a burst |
| acc_addr | input | 5 | Register or scratchpad index |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte (combinational) |
| live_time | input | 56 | Live counter values, seven bytes |
| commit_stb | output | 1 | One-cycle commit pulse to the counters |
| commit_mask | output | 7 | Time registers to load on commit |
| commit_time | output | 56 | Values to load on commit |
| charge_en | output | 1 | Decoded charger enable |

## Verification
The hardest case to reach is a clock burst whose outcome depends on its history. Protection must already be set before the burst starts, or the burst must stop one slot short, and the result only shows at the next session. The stimulus first completes a full burst whose control slot sets protection. Next it opens a session and confirms the flag through a read. It then replays a full burst with the flag set. After clearing the flag with a single write, it issues a seven-slot burst. Each case is judged by the commit mask at the session end and by reads in the following session.

// File: rtl/rtc_bank_pkg.sv
`timescale 1ns/1ps
package rtc_bank_pkg;
    localparam int BANK_DW   = 8;
    localparam int BANK_AW   = 5;
    localparam int TIME_REGS = 7;
    localparam int RAM_DEPTH = 31;
    localparam logic [3:0] CHG_KEY = 4'b1010;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_COMMIT = 2'd2
    } bank_state_t;
endpackage

// File: rtl/rtc_bank_fsm.sv
`timescale 1ns/1ps
module rtc_bank_fsm
    import rtc_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic snap_stb,
    output logic open,
    output logic commit_phase
);
    bank_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sel)  state_d = ST_OPEN;
            ST_OPEN:   if (!sel) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        snap_stb     = 1'b0;
        open         = 1'b0;
        commit_phase = 1'b0;
        unique case (state_q)
            ST_IDLE:   snap_stb     = sel;
            ST_OPEN:   open         = 1'b1;
            ST_COMMIT: commit_phase = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/rtc_bank_clkregs.sv
`timescale 1ns/1ps
module rtc_bank_clkregs #(
    parameter int DW   = 8,
    parameter int AW   = 5,
    parameter int NREG = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 snap_stb,
    input  logic                 commit_phase,
    input  logic                 wr_en,
    input  logic                 burst,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    input  logic [NREG*DW-1:0]   live_time,
    output logic [DW-1:0]        rd_data,
    output logic                 wp,
    output logic [DW-1:0]        chg_reg,
    output logic [NREG-1:0]      mask_raw,
    output logic [NREG*DW-1:0]   user_time
);
    localparam int IDX_CTRL = NREG;
    localparam int IDX_CHG  = NREG + 1;
    localparam int BLEN     = NREG + 1;

    logic [DW-1:0]   ubuf [NREG];
    logic [NREG-1:0] dirty;
    logic [BLEN-1:0] seen;
    logic            wp_q;
    logic            stage_wp;
    logic [DW-1:0]   chg_q;
    logic            burst_full;

    assign burst_full = &seen;

    // user copy, pending mask and burst slot tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) ubuf[i] <= '0;
            dirty <= '0;
            seen  <= '0;
        end else if (snap_stb) begin
            for (int i = 0; i < NREG; i++) ubuf[i] <= live_time[i*DW +: DW];
            dirty <= '0;
            seen  <= '0;
        end else if (wr_en && !wp_q) begin
            for (int i = 0; i < NREG; i++) begin
                if (addr == AW'(i)) begin
                    ubuf[i] <= wdata;
                    if (!burst) dirty[i] <= 1'b1;
                end
            end
            if (burst) begin
                for (int b = 0; b < BLEN; b++) begin
                    if (addr == AW'(b)) seen[b] <= 1'b1;
                end
            end
        end
    end

    // protection flag: single writes act at once, burst writes wait for commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q     <= 1'b1;
            stage_wp <= 1'b0;
        end else if (commit_phase) begin
            if (burst_full) wp_q <= stage_wp;
        end else if (wr_en && addr == AW'(IDX_CTRL)) begin
            if (!burst)     wp_q     <= wdata[DW-1];
            else if (!wp_q) stage_wp <= wdata[DW-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            chg_q <= '0;
        else if (wr_en && !burst && !wp_q && addr == AW'(IDX_CHG))
            chg_q <= wdata;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == AW'(i)) rd_data = ubuf[i];
        end
        if (addr == AW'(IDX_CTRL)) rd_data = {wp_q, {(DW-1){1'b0}}};
        if (addr == AW'(IDX_CHG))  rd_data = chg_q;
    end

    assign mask_raw = dirty | {NREG{burst_full}};
    assign wp       = wp_q;
    assign chg_reg  = chg_q;

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign user_time[g*DW +: DW] = ubuf[g];
    end
endmodule

// File: rtl/rtc_bank_scratch.sv
`timescale 1ns/1ps
module rtc_bank_scratch #(
    parameter int DW    = 8,
    parameter int AW    = 5,
    parameter int DEPTH = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (addr == AW'(i)) mem[i] <= wdata;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == AW'(i)) rd_data = mem[i];
        end
    end
endmodule

// File: rtl/rtc_bank_chg_decode.sv
`timescale 1ns/1ps
module rtc_bank_chg_decode
    import rtc_bank_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          rst_n,
    input  logic [DW-1:0] chg_reg,
    output logic          charge_en
);
    logic [3:0] key;
    logic [1:0] diodes;
    logic [1:0] resistor;

    assign key      = chg_reg[DW-1 -: 4];
    assign diodes   = chg_reg[3:2];
    assign resistor = chg_reg[1:0];

    always_comb begin
        charge_en = rst_n
                 && (key == CHG_KEY)
                 && (diodes == 2'b01 || diodes == 2'b10)
                 && (resistor != 2'b00);
    end
endmodule

// File: rtl/rtc_shadow_bank.sv
`timescale 1ns/1ps
module rtc_shadow_bank
    import rtc_bank_pkg::*;
#(
    parameter int DW    = BANK_DW,
    parameter int AW    = BANK_AW,
    parameter int NREG  = TIME_REGS,
    parameter int DEPTH = RAM_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 acc_ram,
    input  logic                 acc_burst,
    input  logic [AW-1:0]        acc_addr,
    input  logic [DW-1:0]        acc_wdata,
    output logic [DW-1:0]        acc_rdata,
    input  logic [NREG*DW-1:0]   live_time,
    output logic                 commit_stb,
    output logic [NREG-1:0]      commit_mask,
    output logic [NREG*DW-1:0]   commit_time,
    output logic                 charge_en
);
    logic            snap_stb, open_w, commit_phase;
    logic            wp_w;
    logic [DW-1:0]   chg_w, clk_rd, ram_rd;
    logic [NREG-1:0] mask_raw;
    logic            clk_we, ram_we;

    assign clk_we = open_w && acc_valid && acc_write && !acc_ram;
    assign ram_we = open_w && acc_valid && acc_write && acc_ram && !wp_w;

    rtc_bank_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .snap_stb(snap_stb), .open(open_w), .commit_phase(commit_phase)
    );

    rtc_bank_clkregs #(.DW(DW), .AW(AW), .NREG(NREG)) u_clkregs (
        .clk(clk), .rst_n(rst_n), .snap_stb(snap_stb),
        .commit_phase(commit_phase), .wr_en(clk_we), .burst(acc_burst),
        .addr(acc_addr), .wdata(acc_wdata), .live_time(live_time),
        .rd_data(clk_rd), .wp(wp_w), .chg_reg(chg_w),
        .mask_raw(mask_raw), .user_time(commit_time)
    );

    rtc_bank_scratch #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_scratch (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .addr(acc_addr),
        .wdata(acc_wdata), .rd_data(ram_rd)
    );

    rtc_bank_chg_decode #(.DW(DW)) u_chg (
        .rst_n(rst_n), .chg_reg(chg_w), .charge_en(charge_en)
    );

    always_comb begin
        acc_rdata   = open_w ? (acc_ram ? ram_rd : clk_rd) : '0;
        commit_stb  = commit_phase && (|mask_raw);
        commit_mask = commit_phase ? mask_raw : '0;
    end
endmodule

// File: rtl/rtc_shadow_bank_chk.sv
`timescale 1ns/1ps
module rtc_shadow_bank_chk #(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          acc_valid,
    input logic          acc_write,
    input logic          acc_ram,
    input logic          acc_burst,
    input logic [AW-1:0] acc_addr,
    input logic [DW-1:0] acc_rdata,
    input logic          commit_stb,
    input logic          charge_en,
    input logic          open_w,
    input logic          wp_w,
    input logic [DW-1:0] chg_w
);
    assert_commit_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> !$past(sel));

    assert_commit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> !commit_stb);

    assert_snapshot_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (open_w && $past(open_w) && acc_valid && !acc_write && !acc_ram
         && $past(acc_valid) && !$past(acc_write) && !$past(acc_ram)
         && $stable(acc_addr)) |-> $stable(acc_rdata));

    assert_ctrl_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (open_w && acc_valid && !acc_ram && acc_addr == AW'(7)) |-> (acc_rdata[DW-2:0] == '0));

    assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (open_w && acc_valid && !acc_ram && acc_addr > AW'(8)) |-> (acc_rdata == '0));

    assert_wp_blocks_chg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_w && open_w && acc_valid && acc_write && !acc_ram && !acc_burst
         && acc_addr == AW'(8)) |=> $stable(chg_w));

    assert_chg_reset_R10: assert property (@(posedge clk)
        !rst_n |-> !charge_en);
endmodule

bind rtc_shadow_bank rtc_shadow_bank_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_ram(acc_ram), .acc_burst(acc_burst),
    .acc_addr(acc_addr), .acc_rdata(acc_rdata), .commit_stb(commit_stb),
    .charge_en(charge_en), .open_w(open_w), .wp_w(wp_w), .chg_w(chg_w)
);

// File: tb/rtc_shadow_bank_bench.sv
`timescale 1ns/1ps
module rtc_shadow_bank_bench;
    localparam logic [2:0] OP_LIVE  = 3'd0;
    localparam logic [2:0] OP_OPEN  = 3'd1;
    localparam logic [2:0] OP_CLOSE = 3'd2;
    localparam logic [2:0] OP_WR    = 3'd3;
    localparam logic [2:0] OP_RD    = 3'd4;
    localparam logic [2:0] OP_CHG   = 3'd5;

    typedef struct packed {
        logic [2:0] op;
        logic       ram;
        logic       burst;
        logic [4:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t TBL [NV] = '{
        '{OP_LIVE,  1'b0, 1'b0, 5'd0,  8'h30, 8'h00, 4'd1},
        '{OP_LIVE,  1'b0, 1'b0, 5'd1,  8'h15, 8'h00, 4'd1},
        '{OP_OPEN,  1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 4'd1},
        '{OP_RD,    1'b0, 1'b0, 5'd7,  8'h00, 8'h80, 4'd10}, // R10 protection set after reset
        '{OP_RD,    1'b0, 1'b0, 5'd0,  8'h00, 8'h30, 4'd1},  // R1 snapshot
        '{OP_LIVE,  1'b0, 1'b0, 5'd0,  8'h31, 8'h00, 4'd1},
        '{OP_RD,    1'b0, 1'b0, 5'd0,  8'h00, 8'h30, 4'd1},  // R1 frozen copy
        '{OP_WR,    1'b0, 1'b0, 5'd0,  8'h45, 8'h00, 4'd5},
        '{OP_RD,    1'b0, 1'b0, 5'd0,  8'h00, 8'h30, 4'd5},  // R5 time write dropped
        '{OP_WR,    1'b1, 1'b0, 5'd3,  8'h5A, 8'h00, 4'd5},
        '{OP_RD,    1'b1, 1'b0, 5'd3,  8'h00, 8'h00, 4'd5},  // R5 scratch write dropped
        '{OP_WR,    1'b0, 1'b0, 5'd8,  8'hA5, 8'h00, 4'd5},
        '{OP_CHG,   1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 4'd5},  // R5 charger write dropped
        '{OP_WR,    1'b0, 1'b0, 5'd7,  8'h7F, 8'h00, 4'd7},
        '{OP_RD,    1'b0, 1'b0, 5'd7,  8'h00, 8'h00, 4'd7},  // R7 reserved bits read 0
        '{OP_WR,    1'b0, 1'b0, 5'd1,  8'h22, 8'h00, 4'd2},
        '{OP_RD,    1'b0, 1'b0, 5'd1,  8'h00, 8'h22, 4'd2},  // R2 user copy updated
        '{OP_WR,    1'b1, 1'b0, 5'd3,  8'h5A, 8'h00, 4'd4},
        '{OP_RD,    1'b1, 1'b0, 5'd3,  8'h00, 8'h5A, 4'd4},  // R4 immediate store
        '{OP_WR,    1'b1, 1'b0, 5'd31, 8'h77, 8'h00, 4'd9},
        '{OP_RD,    1'b1, 1'b0, 5'd31, 8'h00, 8'h00, 4'd9},  // R9 scratch index 31
        '{OP_WR,    1'b0, 1'b0, 5'd9,  8'h11, 8'h00, 4'd9},
        '{OP_RD,    1'b0, 1'b0, 5'd9,  8'h00, 8'h00, 4'd9},  // R9 clock index 9
        '{OP_WR,    1'b0, 1'b0, 5'd8,  8'hA5, 8'h00, 4'd8},
        '{OP_CHG,   1'b0, 1'b0, 5'd0,  8'h00, 8'h01, 4'd8},  // R8 key, one diode, r1
        '{OP_RD,    1'b0, 1'b0, 5'd8,  8'h00, 8'hA5, 4'd8},
        '{OP_CLOSE, 1'b0, 1'b0, 5'd1,  8'h22, 8'h02, 4'd2},  // R2 mask and value
        '{OP_OPEN,  1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 4'd1},
        '{OP_RD,    1'b0, 1'b0, 5'd0,  8'h00, 8'h31, 4'd1},  // R1 new snapshot
        '{OP_WR,    1'b0, 1'b0, 5'd8,  8'hA4, 8'h00, 4'd8},
        '{OP_CHG,   1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 4'd8},  // R8 resistor 00
        '{OP_WR,    1'b0, 1'b0, 5'd8,  8'hAD, 8'h00, 4'd8},
        '{OP_CHG,   1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 4'd8},  // R8 diodes 11
        '{OP_WR,    1'b0, 1'b0, 5'd8,  8'hB5, 8'h00, 4'd8},
        '{OP_CHG,   1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 4'd8},  // R8 wrong key
        '{OP_WR,    1'b0, 1'b0, 5'd8,  8'hA9, 8'h00, 4'd8},
        '{OP_CHG,   1'b0, 1'b0, 5'd0,  8'h00, 8'h01, 4'd8},  // R8 two diodes
        '{OP_WR,    1'b0, 1'b1, 5'd8,  8'h00, 8'h00, 4'd9},
        '{OP_CHG,   1'b0, 1'b0, 5'd0,  8'h00, 8'h01, 4'd9},  // R9 burst cannot reach charger
        '{OP_CLOSE, 1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 4'd2}   // R2 nothing pending
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_ram = 1'b0, acc_burst = 1'b0;
    logic [4:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic [55:0] live_time = '0;
    logic        commit_stb;
    logic [6:0]  commit_mask;
    logic [55:0] commit_time;
    logic        charge_en;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_shadow_bank u_rtc_shadow_bank (
        .clk(clk), .rst_n(rst_n), .sel(sel), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_ram(acc_ram), .acc_burst(acc_burst),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .live_time(live_time), .commit_stb(commit_stb),
        .commit_mask(commit_mask), .commit_time(commit_time),
        .charge_en(charge_en)
    );

    task automatic check(input bit ok, input int req, input logic [7:0] act,
                         input logic [7:0] exp, input string what);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic ram, input logic burst,
                          input logic [4:0] addr, input logic [7:0] data,
                          input logic [7:0] exp, input int req);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_ram = ram;
        acc_burst = burst; acc_addr = addr; acc_wdata = data;
        case (op)
            OP_LIVE: live_time[addr*8 +: 8] = data;
            OP_OPEN: sel = 1'b1;
            OP_WR: begin acc_valid = 1'b1; acc_write = 1'b1; end
            OP_RD: begin
                acc_valid = 1'b1;
                #1 check(acc_rdata == exp, req, acc_rdata, exp, "read");
            end
            OP_CHG: begin
                #1 check(charge_en == exp[0], req, {7'd0, charge_en}, exp, "charge_en");
            end
            OP_CLOSE: begin
                sel = 1'b0;
                @(negedge clk);
                #1 check(commit_stb == (exp != 8'h00) && commit_mask == exp[6:0]
                         && (exp == 8'h00 || commit_time[addr*8 +: 8] == data),
                         req, {1'b0, commit_mask}, exp, "commit mask/value");
            end
            default: ;
        endcase
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 check(charge_en == 1'b0 && commit_stb == 1'b0, 10,
                 {6'd0, commit_stb, charge_en}, 8'h00, "reset outputs");
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++)
            run_op(TBL[k].op, TBL[k].ram, TBL[k].burst, TBL[k].addr,
                   TBL[k].data, TBL[k].exp, int'(TBL[k].req));

        // R3: full clock burst, slot 7 sets protection
        run_op(OP_OPEN, 0, 0, 0, 0, 0, 3);
        for (int i = 0; i < 7; i++) run_op(OP_WR, 0, 1, 5'(i), 8'(8'h10 + i), 0, 3);
        run_op(OP_WR, 0, 1, 7, 8'h80, 0, 3);
        run_op(OP_CLOSE, 0, 0, 0, 8'h10, 8'h7F, 3);
        run_op(OP_OPEN, 0, 0, 0, 0, 0, 3);
        run_op(OP_RD, 0, 0, 7, 0, 8'h80, 3);

        // R6: full burst while protected changes nothing
        for (int i = 0; i < 7; i++) run_op(OP_WR, 0, 1, 5'(i), 8'h55, 0, 6);
        run_op(OP_WR, 0, 1, 7, 8'h00, 0, 6);
        run_op(OP_RD, 0, 0, 0, 0, 8'h31, 6);
        run_op(OP_CLOSE, 0, 0, 0, 0, 8'h00, 6);
        run_op(OP_OPEN, 0, 0, 0, 0, 0, 6);
        run_op(OP_RD, 0, 0, 7, 0, 8'h80, 6);

        // R3: seven-slot burst commits nothing
        run_op(OP_WR, 0, 0, 7, 8'h00, 0, 3);
        for (int i = 0; i < 7; i++) run_op(OP_WR, 0, 1, 5'(i), 8'(8'h40 + i), 0, 3);
        run_op(OP_CLOSE, 0, 0, 0, 0, 8'h00, 3);

        // R4: cut-short scratchpad burst keeps its bytes
        run_op(OP_OPEN, 0, 0, 0, 0, 0, 4);
        run_op(OP_WR, 1, 1, 0, 8'h11, 0, 4);
        run_op(OP_WR, 1, 1, 1, 8'h12, 0, 4);
        run_op(OP_CLOSE, 0, 0, 0, 0, 8'h00, 4);
        run_op(OP_OPEN, 0, 0, 0, 0, 0, 4);
        run_op(OP_RD, 1, 0, 1, 0, 8'h12, 4);
        run_op(OP_RD, 1, 0, 0, 0, 8'h11, 4);
        run_op(OP_CLOSE, 0, 0, 0, 0, 8'h00, 4);

        // R11: accesses while idle are ignored and read zero
        run_op(OP_WR, 1, 0, 5, 8'h66, 0, 11);
        run_op(OP_RD, 1, 0, 3, 0, 8'h00, 11);
        run_op(OP_OPEN, 0, 0, 0, 0, 0, 11);
        run_op(OP_RD, 1, 0, 5, 0, 8'h00, 11);
        run_op(OP_CLOSE, 0, 0, 0, 0, 8'h00, 11);

        // R10: reset while the charger is enabled
        run_op(OP_CHG, 0, 0, 0, 0, 8'h01, 10);
        @(negedge clk);
        rst_n = 1'b0;
        #1 check(charge_en == 1'b0, 10, {7'd0, charge_en}, 8'h00, "charge_en in reset");
        @(negedge clk);
        rst_n = 1'b1;
        run_op(OP_OPEN, 0, 0, 0, 0, 0, 10);
        run_op(OP_RD, 0, 0, 7, 0, 8'h80, 10);
        run_op(OP_RD, 0, 0, 8, 0, 8'h00, 10);
        run_op(OP_RD, 1, 0, 3, 0, 8'h00, 10);
        run_op(OP_CLOSE, 0, 0, 0, 0, 8'h00, 10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule